// File: doc/BRIEF.md
# Bit-serial SHA-256 hashing core

This core computes the SHA-256 digest of a message that enters one bit per clock. The received bits accumulate in a 512-bit block register. When the message ends, the core appends the padding itself: a single one bit, then zeros, then the 64-bit bit count. The padding is generated on-chip, also one bit per clock. When a block is complete, an iterative compression engine runs one round per clock over a rolling sixteen-word message schedule. It then adds the working state into the chaining value. Once the final block has been absorbed, the 256-bit digest leaves the core serially.

The input is a valid/ready stream. A bit transfers only on a cycle where `in_valid` and `in_ready` are both high, and `in_last` marks the final bit of the message. The source may hold `in_valid` low for any number of cycles. The core lowers `in_ready` while it compresses a block, while it pads, and while it emits a digest. A source that sees `in_ready` low keeps its bit and flags unchanged. The output has no ready: once started, a digest streams for 256 consecutive cycles and cannot be stalled. The next message may start only after that.

Top module: `sha256_bitser`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: A bit is consumed only on a cycle with `in_valid` and `in_ready` both high; idle cycles inserted between bits leave the digest unchanged.
- R3: The digest equals SHA-256 of the received bit string, where the first bit received is the most significant bit of message word 0 and words are big-endian.
- R4: Padding appends a 1 bit after the last message bit, then zeros, then the 64-bit message length in bits, most significant bit first, in bits 448..511 of the last block. When 448 or more bits of the final block are already used, one extra block is produced.
- R5: Hashing starts from the standard initial value, and each 512-bit block updates the chaining value, so messages spanning several blocks hash correctly.
- R6: `in_ready` is low in the cycle after the last bit is accepted, throughout every compression, and whenever `out_valid` is high.
- R7: `out_valid` stays high for exactly 256 consecutive cycles per message, and `out_bit` carries the digest from the most significant bit of word H0 down to the least significant bit of H7.
- R8: When the digest ends, `in_ready` returns to 1 and the next message hashes from the initial value with a cleared length count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a message bit |
| in_ready | output | 1 | Core can take a message bit this cycle |
| in_bit | input | 1 | Message bit |
| in_last | input | 1 | Offered bit is the final bit of the message |
| out_valid | output | 1 | Digest bit is present on `out_bit` |
| out_bit | output | 1 | Serial digest bit |

## Verification
A fault in the round logic, the schedule window or the chaining adder changes the digest. Because SHA-256 diffuses every bit, a single corrupted bit shows up as roughly half the output bits flipping in that message. A fault in the padding phase or in the bit and length counters shows only at certain message lengths, so the bench sweeps lengths densely around 448 and 512 bits. A sequencing fault shows at the ports within one message: `in_ready` high during a stall, a digest run that is not 256 cycles long, or a second message that does not start from the initial value.

// File: rtl/sha_bs_pkg.sv
package sha_bs_pkg;
  localparam int WORD_W  = 32;
  localparam int BLOCK_W = 512;
  localparam int STATE_W = 256;
  localparam int LEN_W   = 64;
  localparam int ROUNDS  = 64;
  localparam int NWORDS  = BLOCK_W / WORD_W;
  localparam int NSTATE  = STATE_W / WORD_W;
  localparam int POS_W   = $clog2(BLOCK_W);
  localparam int RND_W   = $clog2(ROUNDS);
  localparam int LEN_POS = BLOCK_W - LEN_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {PH_MSG, PH_ONE, PH_ZERO, PH_LEN} pad_phase_t;
  typedef enum logic [2:0] {ST_FILL, ST_LOAD, ST_COMP, ST_SER, ST_OUT} ctl_state_t;

  localparam logic [STATE_W-1:0] INIT_CHAIN = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majority(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic word_t round_k(input logic [RND_W-1:0] t);
    case (t)
      6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491;
      6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1;
      6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01;
      6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe;
      6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786;
      6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa;
      6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d;
      6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147;
      6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138;
      6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb;
      6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b;
      6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624;
      6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08;
      6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a;
      6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f;
      6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb;
      6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
    endcase
  endfunction
endpackage

// File: rtl/sha_bs_collect.sv
module sha_bs_collect #(
  parameter int BW = 512,
  parameter int LW = 64,
  localparam int PW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          sbit,
  input  logic          len_inc,
  input  logic          len_clr,
  output logic [BW-1:0] blk,
  output logic [PW-1:0] pos,
  output logic [LW-1:0] len
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk <= '0;
      pos <= '0;
      len <= '0;
    end else begin
      if (shift_en) begin
        blk <= {blk[BW-2:0], sbit};
        pos <= pos + 1'b1;
      end
      if (len_clr)      len <= '0;
      else if (len_inc) len <= len + 1'b1;
    end
  end
endmodule

// File: rtl/sha_bs_compress.sv
module sha_bs_compress
  import sha_bs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               start,
  input  logic [BLOCK_W-1:0] blk,
  output logic [STATE_W-1:0] chain,
  output logic               done
);
  word_t hq  [NSTATE];
  word_t wk  [NSTATE];
  word_t win [NWORDS];
  logic [RND_W-1:0] rnd;
  logic run, fin;

  word_t t1, t2, w_new;

  always_comb begin
    t1    = wk[7] + big_s1(wk[4]) + choose(wk[4], wk[5], wk[6]) + round_k(rnd) + win[0];
    t2    = big_s0(wk[0]) + majority(wk[0], wk[1], wk[2]);
    w_new = sml_s1(win[14]) + win[9] + sml_s0(win[1]) + win[0];
  end

  for (genvar g = 0; g < NSTATE; g++) begin : g_chain
    assign chain[STATE_W-1-WORD_W*g -: WORD_W] = hq[g];
  end

  assign done = fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NSTATE; j++) begin
        hq[j] <= INIT_CHAIN[STATE_W-1-WORD_W*j -: WORD_W];
        wk[j] <= '0;
      end
      for (int j = 0; j < NWORDS; j++) win[j] <= '0;
      rnd <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      if (init) begin
        for (int j = 0; j < NSTATE; j++)
          hq[j] <= INIT_CHAIN[STATE_W-1-WORD_W*j -: WORD_W];
      end
      if (start) begin
        for (int j = 0; j < NSTATE; j++) wk[j] <= hq[j];
        for (int j = 0; j < NWORDS; j++) win[j] <= blk[BLOCK_W-1-WORD_W*j -: WORD_W];
        rnd <= '0;
        run <= 1'b1;
      end else if (run) begin
        wk[0] <= t1 + t2;
        wk[1] <= wk[0];
        wk[2] <= wk[1];
        wk[3] <= wk[2];
        wk[4] <= wk[3] + t1;
        wk[5] <= wk[4];
        wk[6] <= wk[5];
        wk[7] <= wk[6];
        for (int j = 0; j < NWORDS-1; j++) win[j] <= win[j+1];
        win[NWORDS-1] <= w_new;
        rnd <= rnd + 1'b1;
        if (rnd == RND_W'(ROUNDS-1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
      if (fin) begin
        for (int j = 0; j < NSTATE; j++) hq[j] <= hq[j] + wk[j];
        fin <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sha_bs_serout.sv
module sha_bs_serout #(
  parameter int DW = 256,
  localparam int CW = $clog2(DW+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          dvalid,
  output logic          dbit,
  output logic          dlast
);
  logic [DW-1:0] sr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (load) begin
      sr  <= din;
      cnt <= CW'(DW);
    end else if (cnt != '0) begin
      sr  <= {sr[DW-2:0], 1'b0};
      cnt <= cnt - 1'b1;
    end
  end

  assign dvalid = (cnt != '0);
  assign dbit   = sr[DW-1];
  assign dlast  = (cnt == CW'(1));
endmodule

// File: rtl/sha256_bitser.sv
module sha256_bitser
  import sha_bs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_last,
  output logic out_valid,
  output logic out_bit
);
  ctl_state_t st;
  pad_phase_t ph;
  logic       last_blk;

  logic [BLOCK_W-1:0] blk;
  logic [POS_W-1:0]   pos, pos_nx;
  logic [LEN_W-1:0]   len;
  logic [STATE_W-1:0] chain;
  logic shift_en, sbit, len_inc, len_clr, block_full;
  logic comp_start, comp_init, comp_done, ser_load, ser_last;

  assign in_ready   = (st == ST_FILL) && (ph == PH_MSG);
  assign shift_en   = (st == ST_FILL) && ((ph != PH_MSG) || in_valid);
  assign len_inc    = in_ready && in_valid;
  assign pos_nx     = pos + 1'b1;
  assign block_full = shift_en && (pos_nx == '0);
  assign comp_start = (st == ST_LOAD);
  assign ser_load   = (st == ST_SER);
  assign comp_init  = (st == ST_OUT) && ser_last;
  assign len_clr    = comp_init;

  always_comb begin
    case (ph)
      PH_MSG:  sbit = in_bit;
      PH_ONE:  sbit = 1'b1;
      PH_ZERO: sbit = 1'b0;
      default: sbit = len[~pos[5:0]];
    endcase
  end

  sha_bs_collect #(.BW(BLOCK_W), .LW(LEN_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sbit(sbit),
    .len_inc(len_inc), .len_clr(len_clr), .blk(blk), .pos(pos), .len(len));

  sha_bs_compress u_comp (
    .clk(clk), .rst_n(rst_n), .init(comp_init), .start(comp_start),
    .blk(blk), .chain(chain), .done(comp_done));

  sha_bs_serout #(.DW(STATE_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .din(chain),
    .dvalid(out_valid), .dbit(out_bit), .dlast(ser_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_FILL;
      ph       <= PH_MSG;
      last_blk <= 1'b0;
    end else begin
      case (st)
        ST_FILL: begin
          if (shift_en) begin
            case (ph)
              PH_MSG:  if (in_last) ph <= PH_ONE;
              PH_ONE, PH_ZERO:
                ph <= (pos_nx == POS_W'(LEN_POS)) ? PH_LEN : PH_ZERO;
              default: if (block_full) ph <= PH_MSG;
            endcase
          end
          if (block_full) begin
            st       <= ST_LOAD;
            last_blk <= (ph == PH_LEN);
          end
        end
        ST_LOAD: st <= ST_COMP;
        ST_COMP: if (comp_done) st <= last_blk ? ST_SER : ST_FILL;
        ST_SER:  st <= ST_OUT;
        default: if (ser_last) st <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/sha256_bitser_chk.sv
module sha256_bitser_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_last,
  input logic out_valid
);
  logic [8:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)         run <= '0;
    else if (out_valid) run <= run + 1'b1;
    else                run <= '0;
  end

  assert_ready_off_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_last_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  assert_run_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (run < 9'd256));

  assert_run_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (run == 9'd256));

  assert_ready_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> in_ready);
endmodule

bind sha256_bitser sha256_bitser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid));

// File: tb/sim_sha256_bitser.sv
module sim_sha256_bitser;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0;
  logic in_ready, out_valid, out_bit;

  int checks = 0, fails = 0, cyc = 0;
  logic mb [0:2047];
  logic [255:0] got;
  int ocnt, first_cyc, last_cyc, stall_cnt, overlap;
  logic [31:0] gx;

  localparam logic [31:0] KT [0:63] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};
  localparam logic [255:0] ABC_DIGEST =
    256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;

  sha256_bitser u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_last(in_last), .out_valid(out_valid), .out_bit(out_bit));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_hash(input int len);
    logic pb [0:2559];
    logic [31:0] w [0:63];
    logic [31:0] hh [0:7];
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    logic [63:0] l64;
    int nb, tot;
    l64 = 64'(len);
    nb  = (len + 65 + 511) / 512;
    tot = nb * 512;
    for (int i = 0; i < tot; i++) pb[i] = (i < len) ? mb[i] : (i == len);
    for (int i = 0; i < 64; i++) pb[tot-64+i] = l64[63-i];
    hh = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
           32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    for (int k = 0; k < nb; k++) begin
      for (int t = 0; t < 16; t++)
        for (int i = 0; i < 32; i++) w[t][31-i] = pb[k*512 + t*32 + i];
      for (int t = 16; t < 64; t++)
        w[t] = (rr(w[t-2],17) ^ rr(w[t-2],19) ^ (w[t-2] >> 10)) + w[t-7]
             + (rr(w[t-15],7) ^ rr(w[t-15],18) ^ (w[t-15] >> 3)) + w[t-16];
      a = hh[0]; b = hh[1]; c = hh[2]; d = hh[3]; e = hh[4]; f = hh[5]; g = hh[6]; h = hh[7];
      for (int t = 0; t < 64; t++) begin
        t1 = h + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + ((e & f) ^ (~e & g)) + KT[t] + w[t];
        t2 = (rr(a,2) ^ rr(a,13) ^ rr(a,22)) + ((a & b) ^ (a & c) ^ (b & c));
        h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
      end
      hh[0] += a; hh[1] += b; hh[2] += c; hh[3] += d;
      hh[4] += e; hh[5] += f; hh[6] += g; hh[7] += h;
    end
    return {hh[0], hh[1], hh[2], hh[3], hh[4], hh[5], hh[6], hh[7]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic gen(input int len, input logic [31:0] seed);
    logic [31:0] x;
    x = seed;
    for (int i = 0; i < len; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      mb[i] = x[7];
    end
  endtask

  // output and stall monitor
  always @(negedge clk) begin
    cyc++;
    if (out_valid) begin
      got = {got[254:0], out_bit};
      if (ocnt == 0) first_cyc = cyc;
      last_cyc = cyc;
      ocnt++;
      if (in_ready) overlap++;
    end
    if (!in_ready) stall_cnt++;
  end

  task automatic run_msg(input int len, input bit gaps, input string req);
    logic [255:0] exp;
    int i, nb;
    exp = ref_hash(len);
    nb  = (len + 65 + 511) / 512;
    ocnt = 0; overlap = 0; stall_cnt = 0;
    i = 0;
    while (i < len) begin
      @(negedge clk);
      gx ^= gx << 13; gx ^= gx >> 17; gx ^= gx << 5;
      if (gaps && gx[1:0] == 2'b00) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_bit   = mb[i];
        in_last  = (i == len - 1);
        if (in_ready) i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    while (ocnt < 256 || out_valid) @(negedge clk);
    check(got == exp, req, $sformatf("digest len %0d", len), got, exp);
    check(ocnt == 256 && (last_cyc - first_cyc) == 255, "R7",
          $sformatf("digest run len %0d", len), 256'(ocnt), 256'd256);
    check(overlap == 0 && stall_cnt >= nb*66 + 256, "R6",
          $sformatf("stall len %0d", len), 256'(stall_cnt), 256'(nb*66 + 256));
    check(in_ready == 1'b1, "R8", "ready after digest", 256'(in_ready), 256'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc >= WDOG_LIMIT) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected < %0d", cyc, WDOG_LIMIT);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [23:0] abc;
    gx = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "reset state",
          {254'd0, in_ready, out_valid}, 256'd2);
    // R3: known-answer for the 24-bit string "abc"
    abc = 24'h616263;
    for (int i = 0; i < 24; i++) mb[i] = abc[23-i];
    check(ref_hash(24) == ABC_DIGEST, "R3", "bench model known answer", ref_hash(24), ABC_DIGEST);
    run_msg(24, 1'b0, "R3");
    check(got == ABC_DIGEST, "R3", "known answer at ports", got, ABC_DIGEST);
    // R2: same message with idle gaps, R8: back-to-back from initial value
    run_msg(24, 1'b1, "R2");
    check(got == ABC_DIGEST, "R8", "second message from initial value", got, ABC_DIGEST);
    // R4: shortest message and lengths around the extra-block boundary
    gen(1, 32'h0000_0051);
    run_msg(1, 1'b0, "R4");
    for (int l = 440; l <= 456; l++) begin
      gen(l, 32'h9e37_79b9 + 32'(l));
      run_msg(l, 1'b0, "R4");
    end
    // R5: lengths around a full block, and multi-block messages
    for (int l = 504; l <= 520; l++) begin
      gen(l, 32'h7f4a_7c15 + 32'(l));
      run_msg(l, (l % 2) == 1, "R5");
    end
    gen(960, 32'hdead_beef);
    run_msg(960, 1'b0, "R5");
    gen(1100, 32'h0bad_cafe);
    run_msg(1100, 1'b1, "R2");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule